// File: doc/BRIEF.md
# Fixed-Destination 16-bit Single-Cycle Processor Core

This block is a small 16-bit processor that finishes one instruction on every clock edge. Register-to-register operations name only two registers, `rt` and `rs`. Each such instruction carries a steering bit. With the bit clear, the result goes to a fixed accumulator register, r7. With the bit set, the result overwrites `rt`. There is no separate jump format, because the 8-bit immediate field covers the whole instruction store.

A host loads the program through a write port while reset is held low, then releases reset. The core runs until it executes a stop instruction. The host can then read any register and any data byte through combinational debug ports, and can see the program counter and the stopped flag. Instruction storage is 128 sixteen-bit words, so the program counter is a byte address that steps by 2. Data storage is 256 bytes.

Top module: `defdst_cpu`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `pc_o` is 0, `halted_o` is 0 and all eight registers read 0. Reset is synchronous.
- R2: The register-operation format is opcode 0 in bits [15:12], steer bit [11], `rt` [10:8], `rs` [7:5] and function [4:0]. The result is R[rt] op R[rs]. With bit 11 = 0 it is written to r7 and `rt` is left unchanged.
- R3: With bit 11 = 1, the register-operation result is written to `rt` and r7 is left unchanged.
- R4: Function codes 0 (add), 1 (subtract) and 2 (multiply) return the low 16 bits of the two's-complement result.
- R5: Function 3 divides as signed numbers and truncates toward zero. A divisor of 0 gives 0xFFFF and causes no trap. -32768 / -1 gives 0x8000.
- R6: Function codes 4 (AND), 5 (OR), 6 (XOR) and 7 (signed set-less-than, giving 1 or 0) work as named. Function codes 8 to 31 write no register.
- R7: The immediate format is opcode [15:12], bit [11], `rt` [10:8] and imm [7:0]. Opcode 1 adds the sign-extended imm to `rt`. Opcode 2 loads the sign-extended imm into `rt`. Bit 11 has no effect on the destination of these instructions.
- R8: Opcode 4 stores `rt` at byte address imm, low byte at imm and high byte at imm+1 (mod 256). Opcode 3 loads `rt` from the same two bytes.
- R9: Opcode 5 branches when `rt` is zero, opcode 6 branches when `rt` is nonzero, and opcode 7 always jumps. The target byte address is imm with bit 0 cleared.
- R10: Every other executed instruction advances the PC by 2. Opcode 8 sets `halted_o`, after which the PC and all registers stay frozen until reset.
- R11: `prog_we` writes `prog_data` to instruction word `prog_addr`. `dbg_reg_val` shows register `dbg_reg_sel`, and `dbg_mem_byte` shows data byte `dbg_mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 7 | Instruction word index to write |
| prog_data | input | 16 | Instruction word to write |
| dbg_reg_sel | input | 3 | Register to observe |
| dbg_reg_val | output | 16 | Value of the selected register |
| dbg_mem_addr | input | 8 | Data byte to observe |
| dbg_mem_byte | output | 8 | Value of the selected data byte |
| pc_o | output | 8 | Program counter (byte address) |
| halted_o | output | 1 | Core has executed the stop instruction |

## Verification
The assertions assume the instruction store is fully written before reset is released. They also assume the program never runs into words that were never written, so the decoded instruction fields are always defined while the core runs. The bench meets this by loading each program under reset and ending every program, on every path, with a stop instruction that it has written. The sweep operands come only from 8-bit load-immediate values, and multiply and repeated add are used to reach the 16-bit extremes. As a result, each operand the bench uses is known exactly without reading any state inside the design.

// File: rtl/defdst_pkg.sv
// Shared encodings and control types for the fixed-destination core.
// Assumes 16-bit instructions with 3-bit register fields.
package defdst_pkg;
    localparam int XLEN = 16;
    localparam int NREG = 8;
    localparam logic [2:0] DEF_DST = 3'd7;

    localparam logic [3:0] OP_REG  = 4'd0;
    localparam logic [3:0] OP_ADDI = 4'd1;
    localparam logic [3:0] OP_LDI  = 4'd2;
    localparam logic [3:0] OP_LW   = 4'd3;
    localparam logic [3:0] OP_SW   = 4'd4;
    localparam logic [3:0] OP_BZ   = 4'd5;
    localparam logic [3:0] OP_BNZ  = 4'd6;
    localparam logic [3:0] OP_JMP  = 4'd7;
    localparam logic [3:0] OP_STOP = 4'd8;

    localparam logic [2:0] AL_ADD = 3'd0;
    localparam logic [2:0] AL_SUB = 3'd1;
    localparam logic [2:0] AL_MUL = 3'd2;
    localparam logic [2:0] AL_DIV = 3'd3;
    localparam logic [2:0] AL_AND = 3'd4;
    localparam logic [2:0] AL_OR  = 3'd5;
    localparam logic [2:0] AL_XOR = 3'd6;
    localparam logic [2:0] AL_SLT = 3'd7;

    typedef enum logic [1:0] {WB_ALU = 2'd0, WB_IMM = 2'd1, WB_MEM = 2'd2} wb_e;
    typedef enum logic [1:0] {PC_SEQ = 2'd0, PC_JMP = 2'd1, PC_BZ = 2'd2, PC_BNZ = 2'd3} pcsel_e;

    typedef struct packed {
        logic       rf_we;
        logic [2:0] waddr;
        wb_e        wb;
        logic [2:0] alu_op;
        logic       alu_imm;
        logic       mem_we;
        pcsel_e     pcs;
        logic       stop;
    } ctl_t;
endpackage

// File: rtl/defdst_decode.sv
// Instruction decoder: turns one 16-bit word into control fields.
// Assumes the opcode in [15:12]; unknown opcodes decode as no-ops.
module defdst_decode
    import defdst_pkg::*;
(
    input  logic [15:0] instr,
    output ctl_t        ctl,
    output logic [2:0]  rt,
    output logic [2:0]  rs,
    output logic [7:0]  imm
);
    assign rt  = instr[10:8];
    assign rs  = instr[7:5];
    assign imm = instr[7:0];

    // Map opcode (and function for register ops) to control signals.
    always_comb begin
        ctl        = '0;
        ctl.wb     = WB_ALU;
        ctl.pcs    = PC_SEQ;
        ctl.waddr  = instr[10:8];
        ctl.alu_op = AL_ADD;
        case (instr[15:12])
            OP_REG: begin
                if (instr[4:3] == 2'b00) begin
                    ctl.rf_we  = 1'b1;
                    ctl.alu_op = instr[2:0];
                    ctl.waddr  = instr[11] ? instr[10:8] : DEF_DST;
                end
            end
            OP_ADDI: begin
                ctl.rf_we   = 1'b1;
                ctl.alu_imm = 1'b1;
            end
            OP_LDI: begin
                ctl.rf_we = 1'b1;
                ctl.wb    = WB_IMM;
            end
            OP_LW: begin
                ctl.rf_we = 1'b1;
                ctl.wb    = WB_MEM;
            end
            OP_SW:   ctl.mem_we = 1'b1;
            OP_BZ:   ctl.pcs    = PC_BZ;
            OP_BNZ:  ctl.pcs    = PC_BNZ;
            OP_JMP:  ctl.pcs    = PC_JMP;
            OP_STOP: ctl.stop   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/defdst_alu.sv
// Combinational ALU: add, sub, low-half multiply, signed divide, logic, compare.
// Divide by zero returns all ones; the divide truncates toward zero.
module defdst_alu
    import defdst_pkg::*;
#(
    parameter int W = XLEN
)(
    input  logic [2:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] mag_a, mag_b, mag_q;
    logic         neg_q;

    // Unsigned divide on magnitudes, sign restored afterwards.
    always_comb begin
        mag_a = a[W-1] ? (~a + 1'b1) : a;
        mag_b = b[W-1] ? (~b + 1'b1) : b;
        neg_q = a[W-1] ^ b[W-1];
        mag_q = (mag_b == '0) ? '1 : (mag_a / mag_b);
    end

    // Select the operation result.
    always_comb begin
        case (op)
            AL_ADD:  y = a + b;
            AL_SUB:  y = a - b;
            AL_MUL:  y = a * b;
            AL_DIV:  y = (b == '0) ? '1 : (neg_q ? (~mag_q + 1'b1) : mag_q);
            AL_AND:  y = a & b;
            AL_OR:   y = a | b;
            AL_XOR:  y = a ^ b;
            default: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
        endcase
    end
endmodule

// File: rtl/defdst_regfile.sv
// Register file: two read ports, one write port, one debug read port.
// All registers clear on synchronous active-low reset.
module defdst_regfile #(
    parameter int NR = 8,
    parameter int W  = 16,
    localparam int RW = $clog2(NR)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [RW-1:0] ra,
    input  logic [RW-1:0] rb,
    input  logic [RW-1:0] rd,
    output logic [W-1:0]  qa,
    output logic [W-1:0]  qb,
    output logic [W-1:0]  qd
);
    logic [W-1:0] regs_q [NR];

    for (genvar g = 0; g < NR; g++) begin : g_reg
        // One register: clear on reset, load when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (we && waddr == RW'(g))
                regs_q[g] <= wdata;
        end
    end

    assign qa = regs_q[ra];
    assign qb = regs_q[rb];
    assign qd = regs_q[rd];
endmodule

// File: rtl/defdst_dmem.sv
// Byte-wide data store with little-endian 16-bit access; address+1 wraps.
// Contents are not reset.
module defdst_dmem #(
    parameter int NB = 256,
    localparam int AW = $clog2(NB)
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    input  logic [AW-1:0] dbg_addr,
    output logic [7:0]    dbg_byte
);
    logic [7:0]    mem_q [NB];
    logic [AW-1:0] addr_hi;

    assign addr_hi = addr + 1'b1;

    // Store both bytes of a word in one cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr]    <= wdata[7:0];
            mem_q[addr_hi] <= wdata[15:8];
        end
    end

    assign rdata    = {mem_q[addr_hi], mem_q[addr]};
    assign dbg_byte = mem_q[dbg_addr];
endmodule

// File: rtl/defdst_cpu.sv
// Single-cycle 16-bit core with a fixed default destination register.
// Assumes the program is loaded before reset is released and ends in a stop.
module defdst_cpu
    import defdst_pkg::*;
#(
    parameter int IMEM_WORDS = 128,
    parameter int DMEM_BYTES = 256,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_BYTES),
    localparam int PCW = IAW + 1
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog_we,
    input  logic [IAW-1:0]  prog_addr,
    input  logic [15:0]     prog_data,
    input  logic [2:0]      dbg_reg_sel,
    output logic [15:0]     dbg_reg_val,
    input  logic [DAW-1:0]  dbg_mem_addr,
    output logic [7:0]      dbg_mem_byte,
    output logic [PCW-1:0]  pc_o,
    output logic            halted_o
);
    logic [15:0]    imem_q [IMEM_WORDS];
    logic [PCW-1:0] pc_q, pc_nx, br_tgt;
    logic           halted_q;
    logic [15:0]    instr;
    ctl_t           ctl;
    logic [2:0]     rt, rs;
    logic [7:0]     imm;
    logic [15:0]    rt_val, rs_val, imm_x, alu_b, alu_y, mem_rd, wdata;
    logic           rf_we_g, mem_we_g;

    // Program load port into the instruction store.
    always_ff @(posedge clk) begin
        if (prog_we)
            imem_q[prog_addr] <= prog_data;
    end

    assign instr = imem_q[pc_q[PCW-1:1]];

    defdst_decode u_dec (.instr(instr), .ctl(ctl), .rt(rt), .rs(rs), .imm(imm));

    assign rf_we_g  = ctl.rf_we & ~halted_q & rst_n;
    assign mem_we_g = ctl.mem_we & ~halted_q & rst_n;
    assign imm_x    = {{8{imm[7]}}, imm};
    assign alu_b    = ctl.alu_imm ? imm_x : rs_val;

    defdst_regfile #(.NR(NREG), .W(XLEN)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we_g), .waddr(ctl.waddr), .wdata(wdata),
        .ra(rt), .rb(rs), .rd(dbg_reg_sel),
        .qa(rt_val), .qb(rs_val), .qd(dbg_reg_val)
    );

    defdst_alu #(.W(XLEN)) u_alu (.op(ctl.alu_op), .a(rt_val), .b(alu_b), .y(alu_y));

    defdst_dmem #(.NB(DMEM_BYTES)) u_dm (
        .clk(clk), .we(mem_we_g), .addr(DAW'(imm)), .wdata(rt_val), .rdata(mem_rd),
        .dbg_addr(dbg_mem_addr), .dbg_byte(dbg_mem_byte)
    );

    // Write-back source selection.
    always_comb begin
        case (ctl.wb)
            WB_IMM:  wdata = imm_x;
            WB_MEM:  wdata = mem_rd;
            default: wdata = alu_y;
        endcase
    end

    assign br_tgt = PCW'({imm[7:1], 1'b0});

    // Next program counter: sequential, jump, conditional branch, or hold on stop.
    always_comb begin
        pc_nx = pc_q + PCW'(2);
        case (ctl.pcs)
            PC_JMP:  pc_nx = br_tgt;
            PC_BZ:   if (rt_val == '0) pc_nx = br_tgt;
            PC_BNZ:  if (rt_val != '0) pc_nx = br_tgt;
            default: ;
        endcase
        if (ctl.stop)
            pc_nx = pc_q;
    end

    // Program counter and stop flag; frozen once stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            halted_q <= 1'b0;
        end else if (!halted_q) begin
            pc_q <= pc_nx;
            if (ctl.stop)
                halted_q <= 1'b1;
        end
    end

    assign pc_o     = pc_q;
    assign halted_o = halted_q;
endmodule

// File: rtl/defdst_chk.sv
// Property checker for defdst_cpu, attached by bind.
// Assumes instruction words are defined whenever the core is running.
module defdst_chk #(
    parameter int PCW = 8
)(
    input logic           clk,
    input logic           rst_n,
    input logic           halted,
    input logic [PCW-1:0] pc,
    input logic [15:0]    instr,
    input logic           rf_we,
    input logic [2:0]     rf_waddr,
    input logic [2:0]     alu_op,
    input logic [15:0]    alu_b,
    input logic [15:0]    alu_y
);
    logic is_regop;
    assign is_regop = !halted && instr[15:12] == 4'd0 && instr[4:3] == 2'b00;

    a_r2_default_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (is_regop && !instr[11]) |-> (rf_we && rf_waddr == 3'd7));

    a_r3_target_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (is_regop && instr[11]) |-> (rf_we && rf_waddr == instr[10:8]));

    a_r5_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && alu_op == 3'd3 && alu_b == 16'd0) |-> alu_y == 16'hFFFF);

    a_r10_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc)));

    a_r10_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && instr[15:12] >= 4'd1 && instr[15:12] <= 4'd4) |=> pc == $past(pc) + PCW'(2));

    a_r9_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> pc[0] == 1'b0);
endmodule

bind defdst_cpu defdst_chk #(.PCW(PCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .halted(halted_q), .pc(pc_q), .instr(instr),
    .rf_we(rf_we_g), .rf_waddr(ctl.waddr), .alu_op(ctl.alu_op),
    .alu_b(alu_b), .alu_y(alu_y)
);

// File: tb/sim_defdst_cpu.sv
`timescale 1ns/1ps
module sim_defdst_cpu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [6:0]  prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic [2:0]  dbg_reg_sel = '0;
    logic [15:0] dbg_reg_val;
    logic [7:0]  dbg_mem_addr = '0;
    logic [7:0]  dbg_mem_byte;
    logic [7:0]  pc_o;
    logic        halted_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] pg [32];
    int pn;

    always #2 clk = ~clk;

    defdst_cpu u0 (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
        .dbg_mem_addr(dbg_mem_addr), .dbg_mem_byte(dbg_mem_byte),
        .pc_o(pc_o), .halted_o(halted_o)
    );

    function automatic logic [15:0] enc_r(input int c, input int rt, input int rs, input int fn);
        return {4'd0, 1'(c), 3'(rt), 3'(rs), 5'(fn)};
    endfunction

    function automatic logic [15:0] enc_i(input int op, input int c, input int rt, input int imm);
        return {4'(op), 1'(c), 3'(rt), 8'(imm)};
    endfunction

    function automatic logic [15:0] model(input int fn, input int a, input int b);
        case (fn)
            0: return 16'(a + b);
            1: return 16'(a - b);
            2: return 16'(a * b);
            3: return (b == 0) ? 16'hFFFF : 16'(a / b);
            4: return 16'(a) & 16'(b);
            5: return 16'(a) | 16'(b);
            6: return 16'(a) ^ 16'(b);
            default: return (a < b) ? 16'd1 : 16'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rdreg(input int i, output logic [15:0] v);
        dbg_reg_sel = 3'(i);
        #1;
        v = dbg_reg_val;
    endtask

    task automatic rdmem(input int a, output logic [7:0] v);
        dbg_mem_addr = 8'(a);
        #1;
        v = dbg_mem_byte;
    endtask

    // Load pg[0..pn-1] under reset (R11), release, run until stop.
    task automatic run_prog();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < pn; i++) begin
            prog_we = 1'b1; prog_addr = 7'(i); prog_data = pg[i];
            @(negedge clk);
        end
        prog_we = 1'b0;
        rst_n = 1'b1;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (halted_o) break;
        end
        chk("R10 stop reached", 16'(halted_o), 16'd1);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog act=running exp=stopped");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, v2;
        logic [7:0]  b0, b1;
        int vals [11] = '{-128, -100, -7, -2, -1, 0, 1, 2, 5, 64, 127};

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 pc", 16'(pc_o), 16'd0);
        chk("R1 halted", 16'(halted_o), 16'd0);
        for (int r = 0; r < 8; r++) begin
            rdreg(r, v);
            chk("R1 reg", v, 16'd0);
        end

        // R2-R6: sweep all functions over operand pairs, alternating steer bit
        for (int fn = 0; fn < 8; fn++) begin
            for (int ia = 0; ia < 11; ia++) begin
                for (int ib = 0; ib < 11; ib++) begin
                    int c;
                    c = (ia + ib) & 1;
                    pg[0] = enc_i(2, 0, 1, vals[ia]);
                    pg[1] = enc_i(2, 0, 2, vals[ib]);
                    pg[2] = enc_r(c, 1, 2, fn);
                    pg[3] = enc_i(8, 0, 0, 0);
                    pn = 4;
                    run_prog();
                    if (c == 0) begin
                        rdreg(7, v);
                        chk(fn < 3 ? "R4 R2 result in r7" : (fn == 3 ? "R5 R2 div in r7" : "R6 R2 logic in r7"),
                            v, model(fn, vals[ia], vals[ib]));
                        rdreg(1, v);
                        chk("R2 rt unchanged", v, 16'(vals[ia]));
                    end else begin
                        rdreg(1, v);
                        chk(fn < 3 ? "R4 R3 result in rt" : (fn == 3 ? "R5 R3 div in rt" : "R6 R3 logic in rt"),
                            v, model(fn, vals[ia], vals[ib]));
                        rdreg(7, v);
                        chk("R3 r7 unchanged", v, 16'd0);
                    end
                end
            end
        end

        // R5: most negative divided by -1; R6: undefined function writes nothing
        pg[0] = enc_i(2, 0, 1, -128);
        pg[1] = enc_i(2, 0, 2, -1);
        for (int k = 0; k < 8; k++) pg[2 + k] = enc_r(1, 1, 1, 0);
        pg[10] = enc_r(0, 1, 2, 3);
        pg[11] = enc_r(1, 2, 1, 9);
        pg[12] = enc_r(0, 2, 1, 20);
        pg[13] = enc_i(8, 0, 0, 0);
        pn = 14;
        run_prog();
        rdreg(1, v);
        chk("R5 operand -32768", v, 16'h8000);
        rdreg(7, v);
        chk("R5 -32768/-1", v, 16'h8000);
        rdreg(2, v);
        chk("R6 undefined function no write", v, 16'hFFFF);

        // R7: immediate forms ignore the steer bit
        pg[0] = enc_i(2, 1, 3, 8'h85);
        pg[1] = enc_i(1, 1, 3, 5);
        pg[2] = enc_i(1, 0, 4, -3);
        pg[3] = enc_i(8, 0, 0, 0);
        pn = 4;
        run_prog();
        rdreg(3, v);
        chk("R7 ldi+addi", v, 16'hFF8A);
        rdreg(4, v);
        chk("R7 addi negative", v, 16'hFFFD);
        rdreg(7, v);
        chk("R7 r7 untouched", v, 16'd0);

        // R8: store/load little-endian with address wrap
        foreach (vals[i]) begin
            int addr;
            if (i > 4) break;
            addr = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 100 : (i == 3) ? 254 : 255;
            pg[0] = enc_i(2, 0, 1, -100);
            pg[1] = enc_i(2, 0, 2, 127 - i);
            pg[2] = enc_r(1, 1, 2, 2);
            pg[3] = enc_i(4, 0, 1, addr);
            pg[4] = enc_i(3, 0, 3, addr);
            pg[5] = enc_i(8, 0, 0, 0);
            pn = 6;
            run_prog();
            v2 = 16'(-100 * (127 - i));
            rdreg(3, v);
            chk("R8 load after store", v, v2);
            rdmem(addr, b0);
            chk("R8 low byte", 16'(b0), 16'(v2[7:0]));
            rdmem((addr + 1) % 256, b1);
            chk("R8 high byte", 16'(b1), 16'(v2[15:8]));
        end

        // R9/R10: branches, jump, odd target, stop PC
        for (int kind = 0; kind < 5; kind++) begin
            int op, val, tgt;
            logic taken;
            op  = (kind < 2) ? 5 : (kind < 4) ? 6 : 7;
            val = kind & 1;
            tgt = (kind == 4) ? 9 : 8;
            taken = (op == 5) ? (val == 0) : (op == 6) ? (val != 0) : 1'b1;
            pg[0] = enc_i(2, 0, 1, val);
            pg[1] = enc_i(op, 0, 1, tgt);
            pg[2] = enc_i(2, 0, 2, 1);
            pg[3] = enc_i(8, 0, 0, 0);
            pg[4] = enc_i(2, 0, 2, 2);
            pg[5] = enc_i(8, 0, 0, 0);
            pn = 6;
            run_prog();
            rdreg(2, v);
            chk("R9 branch path", v, taken ? 16'd2 : 16'd1);
            chk("R10 pc at stop", 16'(pc_o), taken ? 16'd10 : 16'd6);
            repeat (3) @(negedge clk);
            chk("R10 pc frozen", 16'(pc_o), taken ? 16'd10 : 16'd6);
        end

        // R1: registers clear again after a run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rdreg(2, v);
        chk("R1 reg cleared", v, 16'd0);
        chk("R1 pc cleared", 16'(pc_o), 16'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule